// File: doc/BRIEF.md
# Erased Page Detection Unit

This unit sits on the read path from a flash device. It watches each page of read data as it streams in, one byte per accepted beat, and decides whether the page is blank. Every byte contributes its count of zero bits to a running total. When the page is complete, the total is compared against a programmable threshold that was captured when the page began. A low zero count means the cells were left unprogrammed, and the page is then treated as erased.

The zero-count test is then combined with the ECC setting. With ECC switched off, the zero-count test alone decides. With ECC switched on, the unit waits for the decoder's verdict on the page. A page is called erased only when the zero count is low and the decoder also reports an uncorrectable error. A blank page normally fails decoding, so its uncorrectable error is hidden in that case. A real uncorrectable error on a page that is not blank is reported as such.

Results land in a 32-bit sticky status word that software clears by writing ones. Every finished page also raises a page-transfer bit.

The data input is valid/ready. Back-pressure is as follows:
- `rd_ready` drops on the edge that accepts the last byte of a page.
- It stays low until that page has been decided.
- A beat transfers only on an edge where `rd_valid` and `rd_ready` are both high.
- The source must hold its byte and its last marker stable while `rd_ready` is low.

Top module: `erased_page_detect`

## Requirements
- R1: After reset, `status` is all zeros and `rd_ready` is 1.
- R2: The zero bits of every accepted byte of a page are summed. With ECC disabled, status bit 16 (erased) is set when the total is strictly less than the threshold; a total equal to the threshold does not set it.
- R3: With ECC enabled, bit 16 is set only when the zero-count test holds and the page verdict is uncorrectable (`ecc_result` = 2).
- R4: With ECC enabled and a verdict of no error (`ecc_result` = 0) or corrected (`ecc_result` = 1), neither bit 16 nor bit 0 is set, whatever the zero count.
- R5: Status bit 0 (uncorrectable) is set for an ECC-enabled page with an uncorrectable verdict that is not judged erased. For a page judged erased, bit 0 is never set.
- R6: Status bit 15 (page transfer) is set once for every decided page, one clock after the decision.
- R7: Status bits are sticky. A cycle with `clr_wr` high clears exactly the bits that are 1 in `clr_data`. A set event in the same cycle as a clear of that bit leaves the bit at 1. Bits 31..17 and 14..1 always read 0.
- R8: The threshold is captured on the edge that accepts the first byte of a page. Later changes to `erase_thresh` do not affect that page.
- R9: With ECC enabled, the verdict strobe may arrive before or after the last byte. The decision is made once both have been seen, and `rd_ready` is 0 from the acceptance of the last byte until that decision.
- R10: The zero counter saturates at its maximum (65535 with 16-bit width) instead of wrapping. A page of 8193 zero bytes is therefore not erased at threshold 65535.
- R11: With ECC disabled, a page is decided without any verdict strobe, and bit 0 is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_valid | input | 1 | Read byte valid |
| rd_ready | output | 1 | Unit can accept a byte |
| rd_data | input | DATA_W | Read byte |
| rd_last | input | 1 | Marks the last byte of the page |
| ecc_en | input | 1 | ECC enabled for the current page |
| ecc_valid | input | 1 | One-cycle strobe carrying the page verdict |
| ecc_result | input | 2 | Verdict: 0 no error, 1 corrected, 2 uncorrectable |
| erase_thresh | input | CNT_W | Erased-page zero-count threshold |
| clr_wr | input | 1 | Status write strobe (write one to clear) |
| clr_data | input | STAT_W | Bits to clear |
| status | output | STAT_W | Sticky interrupt status |

## Verification
A corrupted zero total or a stale captured threshold does not show up as the page streams in. It first appears in the cycle after the decision, as a wrong bit 16 or bit 0, while bit 15 still rises on time. Every page is therefore scored on the pairing of those three bits rather than on bit 15 alone.

A lost ECC-arrival or last-byte flag shows up in one of two ways:
- `rd_ready` stays low and bit 15 never arrives, so the run stalls.
- `rd_ready` returns early and the next page starts before the current one is decided.

A wrapping counter is visible only on a page long enough to overflow it, so one page is sized to do exactly that.

// File: rtl/erpd_pkg.sv
package erpd_pkg;

  typedef enum logic [1:0] {
    VERDICT_CLEAN = 2'd0,
    VERDICT_FIXED = 2'd1,
    VERDICT_UNCOR = 2'd2,
    VERDICT_RSVD  = 2'd3
  } ecc_verdict_e;

  localparam int unsigned ST_ERASED = 16;
  localparam int unsigned ST_XFER   = 15;
  localparam int unsigned ST_UNCOR  = 0;

endpackage

// File: rtl/erpd_zero_count.sv
module erpd_zero_count #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              first,
  input  logic [DATA_W-1:0] data,
  input  logic [CNT_W-1:0]  thr_in,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  thr_q
);

  localparam int unsigned ZW = $clog2(DATA_W + 1);

  logic [ZW-1:0]    zeros;
  logic [CNT_W-1:0] base;
  logic [CNT_W:0]   sum;

  always_comb begin
    zeros = '0;
    for (int i = 0; i < DATA_W; i++) begin
      zeros = zeros + ZW'(~data[i]);
    end
  end

  assign base = first ? '0 : cnt;
  assign sum  = {1'b0, base} + (CNT_W + 1)'(zeros);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      thr_q <= '0;
    end else begin
      if (beat) begin
        cnt <= sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
      end
      if (first) begin
        thr_q <= thr_in;
      end
    end
  end

  // Counter never goes backwards within a page (no wrap).
  assert_cnt_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !first) |=> (cnt >= $past(cnt)));

  // Captured threshold only moves at a page start.
  assert_thr_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !first |=> $stable(thr_q));

endmodule

// File: rtl/erpd_page_track.sv
module erpd_page_track
  import erpd_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_valid,
  input  logic         rd_last,
  input  logic         ecc_en,
  input  logic         ecc_valid,
  input  logic [1:0]   ecc_result,
  output logic         rd_ready,
  output logic         beat,
  output logic         first,
  output logic         decide,
  output ecc_verdict_e verdict_q
);

  logic in_page;
  logic data_done;
  logic ecc_got;

  assign rd_ready = !data_done;
  assign beat     = rd_valid && rd_ready;
  assign first    = beat && !in_page;
  assign decide   = data_done && (ecc_got || !ecc_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_page   <= 1'b0;
      data_done <= 1'b0;
      ecc_got   <= 1'b0;
      verdict_q <= VERDICT_CLEAN;
    end else begin
      if (beat) begin
        in_page <= !rd_last;
      end
      if (decide) begin
        data_done <= 1'b0;
      end else if (beat && rd_last) begin
        data_done <= 1'b1;
      end
      if (decide) begin
        ecc_got <= 1'b0;
      end else if (ecc_valid && !ecc_got) begin
        ecc_got   <= 1'b1;
        verdict_q <= ecc_verdict_e'(ecc_result);
      end
    end
  end

  // Accepting the last byte closes the input until the page is decided.
  assert_ready_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && rd_last) |=> !rd_ready);

  // ECC off: a finished page is decided without waiting.
  assert_no_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && rd_last && !ecc_en) |=> (decide || ecc_en));

endmodule

// File: rtl/erpd_status.sv
module erpd_status #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_wr,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] status
);

  logic [W-1:0] clr_mask;

  assign clr_mask = clr_wr ? clr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
    end else begin
      status <= (status & ~clr_mask) | set_vec;
    end
  end

  // A set always lands, even against a same-cycle clear.
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

  // Bits cleared and not set read 0 afterwards.
  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((status & $past(clr_data & ~set_vec)) == '0));

endmodule

// File: rtl/erased_page_detect.sv
module erased_page_detect
  import erpd_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_last,
  input  logic              ecc_en,
  input  logic              ecc_valid,
  input  logic [1:0]        ecc_result,
  input  logic [CNT_W-1:0]  erase_thresh,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_data,
  output logic [STAT_W-1:0] status
);

  logic         beat;
  logic         first;
  logic         decide;
  ecc_verdict_e verdict_q;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  thr_q;
  logic              low_zeros;
  logic              is_uncor;
  logic              erased;
  logic              uncor_flag;
  logic [STAT_W-1:0] set_vec;

  erpd_page_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_valid   (rd_valid),
    .rd_last    (rd_last),
    .ecc_en     (ecc_en),
    .ecc_valid  (ecc_valid),
    .ecc_result (ecc_result),
    .rd_ready   (rd_ready),
    .beat       (beat),
    .first      (first),
    .decide     (decide),
    .verdict_q  (verdict_q)
  );

  erpd_zero_count #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_zeros (
    .clk    (clk),
    .rst_n  (rst_n),
    .beat   (beat),
    .first  (first),
    .data   (rd_data),
    .thr_in (erase_thresh),
    .cnt    (cnt),
    .thr_q  (thr_q)
  );

  assign low_zeros  = cnt < thr_q;
  assign is_uncor   = ecc_en && (verdict_q == VERDICT_UNCOR);
  assign erased     = ecc_en ? (low_zeros && is_uncor) : low_zeros;
  assign uncor_flag = is_uncor && !erased;

  always_comb begin
    set_vec = '0;
    if (decide) begin
      set_vec[ST_ERASED] = erased;
      set_vec[ST_XFER]   = 1'b1;
      set_vec[ST_UNCOR]  = uncor_flag;
    end
  end

  erpd_status #(
    .W (STAT_W)
  ) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_wr   (clr_wr),
    .clr_data (clr_data),
    .status   (status)
  );

  // Every decision raises the page-transfer bit on the next edge.
  assert_xfer_per_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    decide |=> status[ST_XFER]);

  // An erased decision never also flags uncorrectable.
  assert_mask_uncor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && low_zeros && is_uncor) |=> !$rose(status[ST_UNCOR]));

endmodule

// File: tb/erased_page_detect_test.sv
module erased_page_detect_test;

  localparam int unsigned STAT_W = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [7:0]  rd_data = '0;
  logic        rd_last = 1'b0;
  logic        ecc_en = 1'b0;
  logic        ecc_valid = 1'b0;
  logic [1:0]  ecc_result = '0;
  logic [15:0] erase_thresh = '0;
  logic        clr_wr = 1'b0;
  logic [31:0] clr_data = '0;
  logic [31:0] status;

  int checks = 0;
  int errors = 0;
  int pages_seen = 0;
  bit mon_en = 1'b0;

  typedef struct {
    logic  er;
    logic  un;
    string tag;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;

  erased_page_detect uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready),
    .rd_data      (rd_data),
    .rd_last      (rd_last),
    .ecc_en       (ecc_en),
    .ecc_valid    (ecc_valid),
    .ecc_result   (ecc_result),
    .erase_thresh (erase_thresh),
    .clr_wr       (clr_wr),
    .clr_data     (clr_data),
    .status       (status)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  // Monitor: pops the expectation when the page-transfer bit rises.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && status[15]) begin
        if (sb.size() == 0) begin
          check(1'b0, "R6 unexpected page", status, 32'h0);
        end else begin
          exp_t e;
          logic [31:0] ev;
          e  = sb.pop_front();
          ev = (32'(e.er) << 16) | (32'h1 << 15) | 32'(e.un);
          check(status == ev, e.tag, status, ev);
        end
        clr_wr   = 1'b1;
        clr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        clr_wr = 1'b0;
        @(negedge clk);
        check(status == 32'h0, "R7 clear after page", status, 32'h0);
        pages_seen++;
      end
    end
  end

  task automatic pulse_ecc(input logic [1:0] res);
    @(negedge clk);
    ecc_valid  = 1'b1;
    ecc_result = res;
    @(negedge clk);
    ecc_valid = 1'b0;
  endtask

  task automatic send_page(input int n, input logic [7:0] seed, input bit vary,
                           input logic [15:0] thr, input logic [15:0] thr_mid,
                           input bit ecc_on, input logic [1:0] res,
                           input bit ecc_first, input string tag);
    int z = 0;
    int target;
    bit zero_ok;
    exp_t e;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = vary ? 8'(seed + 8'(i * 37)) : seed;
      for (int k = 0; k < 8; k++) if (!b[k]) z++;
    end
    if (z > 65535) z = 65535;
    zero_ok = (z < int'(thr));
    e.er  = ecc_on ? (zero_ok && res == 2'd2) : zero_ok;
    e.un  = ecc_on && res == 2'd2 && !e.er;
    e.tag = tag;
    sb.push_back(e);
    target = pages_seen + 1;
    @(negedge clk);
    ecc_en = ecc_on;
    erase_thresh = thr;
    if (ecc_on && ecc_first) pulse_ecc(res);
    for (int i = 0; i < n; i++) begin
      while (!rd_ready) @(negedge clk);
      rd_valid = 1'b1;
      rd_data  = vary ? 8'(seed + 8'(i * 37)) : seed;
      rd_last  = (i == n - 1);
      @(negedge clk);
      if (i == 0) erase_thresh = thr_mid;
    end
    rd_valid = 1'b0;
    rd_last  = 1'b0;
    if (ecc_on && !ecc_first) begin
      check(rd_ready == 1'b0, "R9 ready low awaiting verdict",
            32'(rd_ready), 32'h0);
      repeat (3) @(negedge clk);
      check(rd_ready == 1'b0, "R9 ready still low",
            32'(rd_ready), 32'h0);
      pulse_ecc(res);
    end
    while (pages_seen != target) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(status == 32'h0, "R1 reset status", status, 32'h0);
    check(rd_ready == 1'b1, "R1 reset ready", 32'(rd_ready), 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check(status == 32'h0, "R1 status after reset", status, 32'h0);
    mon_en = 1'b1;

    send_page(4, 8'hFF, 0, 16'd1,  16'd1,  0, 2'd0, 0, "R2 R11 all ones erased");
    send_page(4, 8'h0F, 0, 16'd16, 16'd16, 0, 2'd0, 0, "R2 equal not erased");
    send_page(4, 8'h0F, 0, 16'd17, 16'd17, 0, 2'd0, 0, "R2 below erased");
    send_page(6, 8'hFE, 0, 16'd8,  16'd8,  1, 2'd2, 1, "R3 R5 R9 uncor masked");
    send_page(8, 8'h00, 0, 16'd10, 16'd10, 1, 2'd2, 0, "R5 R9 uncor reported");
    send_page(4, 8'hFF, 0, 16'd8,  16'd8,  1, 2'd0, 0, "R4 clean verdict");
    send_page(4, 8'hFF, 0, 16'd8,  16'd8,  1, 2'd1, 1, "R4 corrected verdict");
    send_page(8, 8'h00, 0, 16'd10, 16'd10, 0, 2'd0, 0, "R11 ecc off no uncor");
    send_page(4, 8'hF0, 0, 16'd20, 16'd0,  0, 2'd0, 0, "R8 thr drop ignored");
    send_page(4, 8'hF0, 0, 16'd5,  16'd900, 0, 2'd0, 0, "R8 thr raise ignored");
    send_page(32, 8'h5A, 1, 16'd130, 16'd130, 1, 2'd2, 0, "R2 R3 varied data");
    send_page(8193, 8'h00, 0, 16'hFFFF, 16'hFFFF, 0, 2'd0, 0, "R10 saturation");
    send_page(3, 8'h7F, 0, 16'd4, 16'd4, 1, 2'd2, 1, "R6 next page after long");

    // Directed: set versus clear in the same cycle, selective clear.
    mon_en = 1'b0;
    @(negedge clk);
    ecc_en = 1'b1;
    erase_thresh = 16'd1;
    rd_valid = 1'b1;
    rd_data  = 8'hFF;
    rd_last  = 1'b0;
    @(negedge clk);
    rd_last = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    rd_last  = 1'b0;
    ecc_valid  = 1'b1;
    ecc_result = 2'd2;
    @(negedge clk);
    ecc_valid = 1'b0;
    clr_wr    = 1'b1;
    clr_data  = 32'hFFFF_FFFF;
    @(negedge clk);
    clr_wr = 1'b0;
    check(status == 32'h0001_8000, "R7 set beats clear", status, 32'h0001_8000);
    @(negedge clk);
    clr_wr   = 1'b1;
    clr_data = 32'h0000_0000;
    @(negedge clk);
    clr_wr = 1'b0;
    check(status == 32'h0001_8000, "R7 zero write keeps", status, 32'h0001_8000);
    clr_wr   = 1'b1;
    clr_data = 32'h0000_8000;
    @(negedge clk);
    clr_wr = 1'b0;
    check(status == 32'h0001_0000, "R7 selective clear", status, 32'h0001_0000);
    clr_wr   = 1'b1;
    clr_data = 32'h0001_0000;
    @(negedge clk);
    clr_wr = 1'b0;
    check(status == 32'h0, "R7 final clear", status, 32'h0);
    check(sb.size() == 0, "R6 all pages scored", 32'(sb.size()), 32'h0);
    finish_run();
  end

endmodule